// File: doc/BRIEF.md
# SPI Command Frame Receiver with CRC-8 Check

This block is the serial front end of a configurable output device. A host shifts command frames in on `sclk`/`sdi`, most significant bit first, and commits each frame with a rising edge on `latch`. After reset a frame is 24 bits: an 8-bit command followed by a 16-bit data word. When `crc_en` is high the frame grows to 32 bits. The host then appends an 8-bit CRC (generator x^8 + x^2 + x + 1, register cleared to zero, no final inversion). The block checks this CRC and passes on only frames whose remainder is zero. A frame that fails is dropped. It sets a sticky fault flag and drives the active-low alarm.

All three serial inputs are brought into the system clock domain through multi-stage synchronizers, and their edges are detected there. An accepted frame appears as a one-cycle `cmd_valid` pulse with `cmd_byte` and `cmd_data`. For readback, the register file presents a 24-bit word on `rd_word` with a one-cycle `rd_load`. The block shifts that word out on `sdo`, with its CRC attached when CRC mode is on.

Top module: `spi_crc_cmd_rx`

## Requirements
- R1: After reset `cmd_valid` is 0, `crc_fault` is 0, `alarm_n` is 1 and `sdo` is 0.
- R2: With `crc_en` low, a `latch` rising edge that follows at least 24 `sclk` rising edges since the previous `latch` commits the last 24 bits received: the first 8 of them go to `cmd_byte` and the last 16 to `cmd_data`.
- R3: With `crc_en` low, a `latch` rising edge that follows fewer than 24 `sclk` rising edges, including none, produces no `cmd_valid`. `cmd_valid` is only ever raised as the result of a `latch` rising edge.
- R4: With `crc_en` high, a frame is 32 bits. Bits 31:8 hold command and data, and bits 7:0 hold the CRC-8 (polynomial 0x07, initial value 0x00, no final XOR) of bits 31:8. A frame with a correct CRC is committed by the following `latch` rising edge.
- R5: With `crc_en` high, the CRC verdict is taken on every 32nd `sclk` rising edge, whether or not `latch` toggles. A bad frame sets the fault without any `latch`. When several frames are sent before a `latch`, only the last complete one is committed.
- R6: A frame with a nonzero remainder sets `crc_fault` to 1 and `alarm_n` to 0, and no `latch` commits it.
- R7: `crc_fault` stays set through later good frames. It is cleared only by committing a good frame whose command byte is 0x96 (which is also passed on), by `crc_en` being low, or by reset.
- R8: With `crc_en` high, a `latch` rising edge with no `sclk` edges since the last one is a no-operation. Any `latch` discards partial bits and realigns, so the next 32 edges form a frame.
- R9: A `rd_load` pulse loads `rd_word`, and `sdo` then presents its most significant bit. One bit shifts out per `sclk` falling edge. In CRC mode 32 bits leave, with the CRC-8 of `rd_word` as the last 8. Otherwise 24 bits leave, followed by zeros.
- R10: A change of `crc_en` clears the bit count and the running CRC, so a frame sent after the change is aligned from its first bit.
- R11: Each commit raises `cmd_valid` for exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, asynchronous |
| sdi | input | 1 | Serial data from host, sampled on `sclk` rise |
| latch | input | 1 | Frame commit strobe, acts on rising edge |
| crc_en | input | 1 | High selects 32-bit frames with CRC check |
| rd_load | input | 1 | One-cycle pulse that loads the readback word |
| rd_word | input | 24 | Readback word from the register file |
| cmd_valid | output | 1 | One-cycle pulse for an accepted frame |
| cmd_byte | output | 8 | Command byte of the accepted frame |
| cmd_data | output | 16 | Data word of the accepted frame |
| crc_fault | output | 1 | Sticky CRC failure flag |
| alarm_n | output | 1 | Active-low alarm, low while the fault is set |
| sdo | output | 1 | Serial readback data |

## Verification
A miscounted bit counter shows at the ports within one frame. In CRC mode it puts the 32nd-edge boundary in the wrong place, so a correct frame raises `crc_fault` as soon as its last bit arrives, before any `latch`. A running CRC that is not cleared between frames shows the same way on the next good frame. A lost fault clear, or one taken at the wrong time, stays visible on `alarm_n` until the next clearing event. A wrong readback register shows on `sdo` within the first bit period after `rd_load`, and a wrong readback CRC shows within the last eight bit periods of the readback.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
   localparam int CRC_W = 8;

   // one serial CRC step, message bit enters at the top of the register
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                 input logic             bit_in,
                                                 input logic [CRC_W-1:0] poly);
      logic fb;
      fb = cur[CRC_W-1] ^ bit_in;
      return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
   endfunction
endpackage

// File: rtl/spi_crc_sync.sv
module spi_crc_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_crc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("spi_crc_sync: W must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= din;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/spi_crc_edge.sv
module spi_crc_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic strobe
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   if (RISING) begin : g_rise
      assign strobe = lvl & ~prev;
   end else begin : g_fall
      assign strobe = ~lvl & prev;
   end
endmodule

// File: rtl/spi_crc_frame_rx.sv
module spi_crc_frame_rx
   import spi_crc_pkg::*;
#(
   parameter int                CMD_W     = 8,
   parameter int                DATA_W    = 16,
   parameter logic [CRC_W-1:0]  POLY      = 8'h07,
   parameter logic [CMD_W-1:0]  SRST_CODE = 8'h96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              sdi,
   input  logic              latch_rise,
   input  logic              crc_en,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_byte,
   output logic [DATA_W-1:0] cmd_data,
   output logic              crc_fault
);
   localparam int PAY_W = CMD_W + DATA_W;
   localparam int FRM_W = PAY_W + CRC_W;
   localparam int CNT_W = $clog2(FRM_W + 1);

   if (PAY_W < CRC_W) begin : g_bad_payload
      $error("spi_crc_frame_rx: payload narrower than CRC");
   end

   logic [FRM_W-1:0] shreg;
   logic [CNT_W-1:0] cnt;
   logic [CRC_W-1:0] crc, crc_nxt;
   logic             ready_ok;   // last edge closed a 32-bit frame that passed (R5)
   logic             mode_q;
   logic [PAY_W-1:0] pay;
   logic             commit;

   always_comb crc_nxt = crc_step(crc, sdi, POLY);

   // payload location depends on frame mode (R2, R4)
   assign pay    = crc_en ? shreg[FRM_W-1:CRC_W] : shreg[PAY_W-1:0];
   assign commit = crc_en ? ready_ok : (cnt >= CNT_W'(PAY_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         cnt       <= '0;
         crc       <= '0;
         ready_ok  <= 1'b0;
         mode_q    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_byte  <= '0;
         cmd_data  <= '0;
         crc_fault <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         mode_q    <= crc_en;
         if (crc_en != mode_q) begin
            // R10: mode change realigns
            cnt      <= '0;
            crc      <= '0;
            ready_ok <= 1'b0;
         end else if (latch_rise) begin
            // R8: any latch realigns; commit only a complete, good frame
            if (commit) begin
               cmd_valid <= 1'b1;
               cmd_byte  <= pay[PAY_W-1 -: CMD_W];
               cmd_data  <= pay[DATA_W-1:0];
               if (crc_en && pay[PAY_W-1 -: CMD_W] == SRST_CODE) crc_fault <= 1'b0; // R7
            end
            cnt      <= '0;
            crc      <= '0;
            ready_ok <= 1'b0;
         end else if (sclk_rise) begin
            shreg    <= {shreg[FRM_W-2:0], sdi};
            ready_ok <= 1'b0;
            if (crc_en) begin
               if (cnt == CNT_W'(FRM_W - 1)) begin
                  // R5: verdict on every frame boundary
                  cnt <= '0;
                  crc <= '0;
                  if (crc_nxt == '0) ready_ok  <= 1'b1;
                  else               crc_fault <= 1'b1; // R6
               end else begin
                  cnt <= cnt + CNT_W'(1);
                  crc <= crc_nxt;
               end
            end else if (cnt < CNT_W'(PAY_W)) begin
               cnt <= cnt + CNT_W'(1);
            end
         end
         if (!crc_en) crc_fault <= 1'b0; // R7
      end
   end
endmodule

// File: rtl/spi_crc_readback_tx.sv
module spi_crc_readback_tx
   import spi_crc_pkg::*;
#(
   parameter int               PAY_W = 24,
   parameter logic [CRC_W-1:0] POLY  = 8'h07
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             rd_load,
   input  logic [PAY_W-1:0] rd_word,
   input  logic             crc_en,
   output logic             sdo
);
   localparam int FRM_W = PAY_W + CRC_W;

   logic [FRM_W-1:0] oreg;
   logic [CRC_W-1:0] rd_crc;

   // R9: CRC over the readback word, MSB first
   always_comb begin
      rd_crc = '0;
      for (int i = PAY_W - 1; i >= 0; i--) rd_crc = crc_step(rd_crc, rd_word[i], POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        oreg <= '0;
      else if (rd_load)  oreg <= {rd_word, (crc_en ? rd_crc : {CRC_W{1'b0}})};
      else if (shift_en) oreg <= {oreg[FRM_W-2:0], 1'b0};
   end

   assign sdo = oreg[FRM_W-1];
endmodule

// File: rtl/spi_crc_cmd_rx.sv
module spi_crc_cmd_rx
   import spi_crc_pkg::*;
#(
   parameter int                CMD_W       = 8,
   parameter int                DATA_W      = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [CRC_W-1:0]  POLY        = 8'h07,
   parameter logic [CMD_W-1:0]  SRST_CODE   = 8'h96,
   parameter bit                SDO_ON_FALL = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sclk,
   input  logic                      sdi,
   input  logic                      latch,
   input  logic                      crc_en,
   input  logic                      rd_load,
   input  logic [CMD_W+DATA_W-1:0]   rd_word,
   output logic                      cmd_valid,
   output logic [CMD_W-1:0]          cmd_byte,
   output logic [DATA_W-1:0]         cmd_data,
   output logic                      crc_fault,
   output logic                      alarm_n,
   output logic                      sdo
);
   localparam int PAY_W = CMD_W + DATA_W;

   if (CMD_W < 1 || DATA_W < 1) begin : g_bad_fields
      $error("spi_crc_cmd_rx: field widths must be positive");
   end

   logic [2:0] sync_lvl;
   logic       sclk_rise;
   logic       sdo_shift;
   logic       latch_rise;

   spi_crc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({latch, sdi, sclk}),
      .lvl   (sync_lvl)
   );

   spi_crc_edge #(.RISING(1'b1)) u_sclk_rise (
      .clk(clk), .rst_n(rst_n), .lvl(sync_lvl[0]), .strobe(sclk_rise)
   );

   spi_crc_edge #(.RISING(!SDO_ON_FALL)) u_sclk_out (
      .clk(clk), .rst_n(rst_n), .lvl(sync_lvl[0]), .strobe(sdo_shift)
   );

   spi_crc_edge #(.RISING(1'b1)) u_latch_rise (
      .clk(clk), .rst_n(rst_n), .lvl(sync_lvl[2]), .strobe(latch_rise)
   );

   spi_crc_frame_rx #(
      .CMD_W(CMD_W), .DATA_W(DATA_W), .POLY(POLY), .SRST_CODE(SRST_CODE)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_rise  (sclk_rise),
      .sdi        (sync_lvl[1]),
      .latch_rise (latch_rise),
      .crc_en     (crc_en),
      .cmd_valid  (cmd_valid),
      .cmd_byte   (cmd_byte),
      .cmd_data   (cmd_data),
      .crc_fault  (crc_fault)
   );

   spi_crc_readback_tx #(.PAY_W(PAY_W), .POLY(POLY)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (sdo_shift),
      .rd_load  (rd_load),
      .rd_word  (rd_word),
      .crc_en   (crc_en),
      .sdo      (sdo)
   );

   assign alarm_n = ~crc_fault; // R6
endmodule

// File: rtl/spi_crc_cmd_rx_chk.sv
module spi_crc_cmd_rx_chk #(
   parameter int               CMD_W     = 8,
   parameter logic [CMD_W-1:0] SRST_CODE = 8'h96
) (
   input logic             clk,
   input logic             rst_n,
   input logic             crc_en,
   input logic             cmd_valid,
   input logic [CMD_W-1:0] cmd_byte,
   input logic             crc_fault,
   input logic             sdo,
   input logic             rd_load,
   input logic             sdo_shift,
   input logic             latch_rise
);
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid); // R11

   AST_VALID_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(latch_rise)); // R3

   AST_FAULT_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(crc_fault) |-> (!$past(crc_en) || (cmd_valid && cmd_byte == SRST_CODE))); // R7

   AST_NO_FAULT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(crc_en) |-> !crc_fault); // R7

   AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_fault) |-> !cmd_valid); // R6

   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdo_shift && !rd_load) |=> $stable(sdo)); // R9
endmodule

bind spi_crc_cmd_rx spi_crc_cmd_rx_chk #(.CMD_W(CMD_W), .SRST_CODE(SRST_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .crc_en     (crc_en),
   .cmd_valid  (cmd_valid),
   .cmd_byte   (cmd_byte),
   .crc_fault  (crc_fault),
   .sdo        (sdo),
   .rd_load    (rd_load),
   .sdo_shift  (sdo_shift),
   .latch_rise (latch_rise)
);

// File: tb/spi_crc_cmd_rx_bench.sv
module spi_crc_cmd_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int NVEC       = 9;

   // {crc mode, payload, CRC corruption mask, bit count}
   localparam logic [38:0] VEC [NVEC] = '{
      {1'b0, 24'h123456, 8'h00, 6'd24},
      {1'b0, 24'hA5F00F, 8'h00, 6'd30},
      {1'b0, 24'h777777, 8'h00, 6'd20},
      {1'b1, 24'h21ABCD, 8'h00, 6'd32},
      {1'b1, 24'h300001, 8'h01, 6'd32},
      {1'b1, 24'h401234, 8'h00, 6'd32},
      {1'b1, 24'h960000, 8'h00, 6'd32},
      {1'b1, 24'h55AA55, 8'h00, 6'd16},
      {1'b1, 24'h000000, 8'h00, 6'd32}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, sdi = 1'b0, latch = 1'b0, crc_en = 1'b0, rd_load = 1'b0;
   logic [23:0] rd_word = '0;
   logic        cmd_valid, crc_fault, alarm_n, sdo;
   logic [7:0]  cmd_byte;
   logic [15:0] cmd_data;

   int   checks = 0, errors = 0, pulse_cnt = 0;
   logic done = 1'b0;
   logic [7:0]  cap_cmd = '0;
   logic [15:0] cap_data = '0;

   spi_crc_cmd_rx u_spi_crc_cmd_rx (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .latch(latch),
      .crc_en(crc_en), .rd_load(rd_load), .rd_word(rd_word),
      .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_data(cmd_data),
      .crc_fault(crc_fault), .alarm_n(alarm_n), .sdo(sdo)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (cmd_valid) begin
         pulse_cnt <= pulse_cnt + 1;
         cap_cmd   <= cmd_byte;
         cap_data  <= cmd_data;
      end
   end

   function automatic logic [7:0] ref_crc(input logic [23:0] p);
      logic [7:0] c = '0;
      for (int i = 23; i >= 0; i--) begin
         if (c[7] ^ p[i]) c = {c[6:0], 1'b0} ^ 8'h07;
         else             c = {c[6:0], 1'b0};
      end
      return c;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         sdi = w[i];
         tick(HALF);
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
      end
      sdi = 1'b0;
      tick(HALF + 4);
   endtask

   task automatic pulse_latch();
      latch = 1'b1;
      tick(HALF);
      latch = 1'b0;
      tick(10);
   endtask

   task automatic read_out(input int n, output logic [31:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         got = {got[30:0], sdo};
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
         tick(HALF);
      end
   endtask

   task automatic set_mode(input logic m);
      if (crc_en != m) begin
         crc_en = m;
         tick(6);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=%h expected=%h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [38:0] e;
      logic        mode, expv, exp_fault;
      logic [23:0] pay;
      logic [7:0]  flip;
      int          n, base;
      logic [31:0] w, got;
      string       rq;

      exp_fault = 1'b0;
      tick(5);
      // R1: reset state
      chk(cmd_valid == 1'b0, "R1", 32'(cmd_valid), 0);
      chk(crc_fault == 1'b0, "R1", 32'(crc_fault), 0);
      chk(alarm_n == 1'b1, "R1", 32'(alarm_n), 1);
      chk(sdo == 1'b0, "R1", 32'(sdo), 0);
      rst_n = 1'b1;
      tick(5);

      // vector table: R2 R3 R4 R6 R7 R11
      for (int v = 0; v < NVEC; v++) begin
         e    = VEC[v];
         mode = e[38];
         pay  = e[37:14];
         flip = e[13:6];
         n    = int'(e[5:0]);
         set_mode(mode);
         w    = mode ? {pay, ref_crc(pay) ^ flip} : {8'h00, pay};
         base = pulse_cnt;
         send(w, n);
         pulse_latch();
         expv = mode ? (n == 32 && flip == 8'h00) : (n >= 24);
         if (!mode) exp_fault = 1'b0;
         else if (n == 32 && flip != 8'h00) exp_fault = 1'b1;
         else if (expv && pay[23:16] == 8'h96) exp_fault = 1'b0;
         rq = mode ? (expv ? "R4" : "R6") : (expv ? "R2" : "R3");
         chk((pulse_cnt - base) == (expv ? 1 : 0), rq, 32'(pulse_cnt - base), expv ? 1 : 0);
         if (expv) begin
            chk(cap_cmd == pay[23:16], rq, 32'(cap_cmd), 32'(pay[23:16]));
            chk(cap_data == pay[15:0], rq, 32'(cap_data), 32'(pay[15:0]));
            chk((pulse_cnt - base) == 1, "R11", 32'(pulse_cnt - base), 1);
         end
         chk(crc_fault == exp_fault, "R7", 32'(crc_fault), 32'(exp_fault));
         chk(alarm_n == !exp_fault, "R6", 32'(alarm_n), 32'(!exp_fault));
      end

      // R5: a bad frame faults on its 32nd edge, no latch
      set_mode(1'b1);
      send({24'h123456, ref_crc(24'h123456) ^ 8'hFF}, 32);
      chk(crc_fault == 1'b1, "R5", 32'(crc_fault), 1);
      chk(alarm_n == 1'b0, "R6", 32'(alarm_n), 0);

      // R7: good non-reset frame keeps fault, disabling CRC clears it
      base = pulse_cnt;
      send({24'h11CAFE, ref_crc(24'h11CAFE)}, 32);
      pulse_latch();
      chk((pulse_cnt - base) == 1, "R7", 32'(pulse_cnt - base), 1);
      chk(crc_fault == 1'b1, "R7", 32'(crc_fault), 1);
      set_mode(1'b0);
      chk(crc_fault == 1'b0, "R7", 32'(crc_fault), 0);
      set_mode(1'b1);

      // R5: two frames before one latch, last one commits
      base = pulse_cnt;
      send({24'h0A1111, ref_crc(24'h0A1111)}, 32);
      send({24'h0BBEEF, ref_crc(24'h0BBEEF)}, 32);
      pulse_latch();
      chk((pulse_cnt - base) == 1, "R5", 32'(pulse_cnt - base), 1);
      chk(cap_cmd == 8'h0B, "R5", 32'(cap_cmd), 32'h0B);
      chk(cap_data == 16'hBEEF, "R5", 32'(cap_data), 32'hBEEF);

      // R8: latch without edges, then stray edges flushed by latch
      base = pulse_cnt;
      pulse_latch();
      chk((pulse_cnt - base) == 0, "R8", 32'(pulse_cnt - base), 0);
      send(32'h5, 3);
      pulse_latch();
      chk((pulse_cnt - base) == 0, "R8", 32'(pulse_cnt - base), 0);
      send({24'h3C0F0F, ref_crc(24'h3C0F0F)}, 32);
      chk(crc_fault == 1'b0, "R8", 32'(crc_fault), 0);
      pulse_latch();
      chk(cap_cmd == 8'h3C && cap_data == 16'h0F0F, "R8", {8'h0, cap_cmd, cap_data}, 32'h3C0F0F);

      // R10: partial bits discarded by mode change
      send(32'h2AA, 10);
      set_mode(1'b0);
      set_mode(1'b1);
      base = pulse_cnt;
      send({24'h6D1357, ref_crc(24'h6D1357)}, 32);
      chk(crc_fault == 1'b0, "R10", 32'(crc_fault), 0);
      pulse_latch();
      chk((pulse_cnt - base) == 1, "R10", 32'(pulse_cnt - base), 1);
      chk(cap_data == 16'h1357, "R10", 32'(cap_data), 32'h1357);

      // R9: readback with and without CRC
      rd_word = 24'hC35A01;
      rd_load = 1'b1;
      tick(1);
      rd_load = 1'b0;
      tick(2);
      read_out(32, got);
      chk(got == {24'hC35A01, ref_crc(24'hC35A01)}, "R9", got, {24'hC35A01, ref_crc(24'hC35A01)});
      set_mode(1'b0);
      rd_word = 24'h5A0F3C;
      rd_load = 1'b1;
      tick(1);
      rd_load = 1'b0;
      tick(2);
      read_out(32, got);
      chk(got == {24'h5A0F3C, 8'h00}, "R9", got, {24'h5A0F3C, 8'h00});

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule